// File: doc/BRIEF.md
# Phase-Accumulator Trigger Clock with Sub-Tick Delay Code

This block produces a programmable trigger clock from one fixed reference clock. A wide phase register gains a frequency word on every enabled reference cycle. Each time the sum carries out of the top bit, the block emits a one-cycle edge strobe and flips a half-rate square output. The edge strobe can only fall on a reference tick, so the block also works out where, inside that tick, the ideal crossing lay. It derives this from the amount left in the register after the carry and the word that caused it, and reports the result as an 8-bit code for an external delay element.

The frequency word is written into a holding register by a load strobe. It moves into the active position only at a carry boundary, or right away if the active word is zero. This keeps the output running through a frequency change without runt or stretched periods. Words that would give periods shorter than the code divider needs are limited to a ceiling. The code comes from a small bit-serial divider that works on the leading bits of the remainder and of the word.

Top module: `nco_fine_edge`

## Requirements
- R1: While reset is high and on the first cycle after it, edge_o, clk_o, fine_vld_o and fine_code_o are all 0, and the active frequency word is zero.
- R2: On each reference cycle with en_i high, the phase register advances by the active word modulo 2^ACC_W. edge_o is high for exactly the one cycle that follows the clock edge at which that sum carried out of bit ACC_W-1.
- R3: With en_i low the phase register holds its value and no edge is produced. When en_i returns high, accumulation resumes from the held phase.
- R4: For a carry that leaves remainder r under active word F, fine_code_o equals floor(256*(F-r)/F) with 256 saturated to 255, to within one code step. 0 means the crossing was at the start of the tick.
- R5: fine_vld_o is a single-cycle pulse, high exactly CODE_W (8) cycles after the matching edge_o cycle, with fine_code_o valid in that cycle.
- R6: A load writes the holding register. The active word takes the holding value at the first clock edge with a carry after the load, so the carry step itself still uses the old word. If the active word is zero, it takes the holding value at the next clock edge. A load at the same edge as a carry waits for the following carry.
- R7: clk_o inverts on every edge_o cycle and is unchanged otherwise.
- R8: A loaded word above floor((2^ACC_W-1)/MIN_PER), with MIN_PER = 12, is replaced by that ceiling, so that carries are at least MIN_PER cycles apart.
- R9: An active word of zero produces no edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Accumulation enable |
| freq_ld_i | input | 1 | Writes freq_word_i into the holding register |
| freq_word_i | input | 64 | Frequency word, output rate = f_ref*F/2^64 |
| edge_o | output | 1 | Coarse edge strobe, one cycle per carry |
| clk_o | output | 1 | Square clock, flips per edge |
| fine_code_o | output | 8 | Sub-tick delay code for the last edge |
| fine_vld_o | output | 1 | One-cycle pulse marking fine_code_o valid |

## Verification
The bench drives a run at a word of 2^60, where every carry lands exactly on zero. A design that does not saturate the case n==d would report code 0 there instead of 255. Loads that arrive mid-period, and loads that coincide with a carry, are checked against an ideal period model. A design that swaps words immediately would show a short or long period and wrong codes. An oversize load must obey the period floor, or the divider would be restarted before it had finished. Enable gaps and a zero word must give silence without losing phase. Random words then cover codes across the full range, and each code is compared to an exact wide-integer division.

// File: rtl/nco_fd_pkg.sv
package nco_fd_pkg;
  typedef enum logic {DV_IDLE, DV_RUN} div_state_e;
endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W   = 64,
  parameter int MIN_PER = 12
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             ld_i,
  input  logic [ACC_W-1:0] word_i,
  output logic             wrap_o,
  output logic [ACC_W-1:0] rem_o,
  output logic [ACC_W-1:0] f_act_o
);
  localparam logic [ACC_W-1:0] F_CEIL = {ACC_W{1'b1}} / ACC_W'(MIN_PER);

  function automatic logic [ACC_W-1:0] limit_word(input logic [ACC_W-1:0] w);
    return (w > F_CEIL) ? F_CEIL : w;
  endfunction

  logic [ACC_W-1:0] phase_q, f_act_q, f_hold_q;
  logic             pend_q;
  logic [ACC_W:0]   sum_w;
  logic             wrap_w, swap_w;

  assign sum_w   = {1'b0, phase_q} + {1'b0, f_act_q};
  assign wrap_w  = en_i && sum_w[ACC_W];
  assign swap_w  = pend_q && (wrap_w || (f_act_q == '0));
  assign wrap_o  = wrap_w;
  assign rem_o   = sum_w[ACC_W-1:0];
  assign f_act_o = f_act_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      phase_q  <= '0;
      f_act_q  <= '0;
      f_hold_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (en_i) phase_q <= sum_w[ACC_W-1:0];
      if (swap_w) begin
        f_act_q <= f_hold_q;
        pend_q  <= 1'b0;
      end
      if (ld_i) begin
        f_hold_q <= limit_word(word_i);
        pend_q   <= 1'b1;
      end
    end
  end

  // R8
  word_ceiling_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    f_act_q <= F_CEIL);
  // R6
  swap_at_boundary_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(f_act_q) |-> ($past(wrap_w) || ($past(f_act_q) == '0)));
  // R9
  zero_silent_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (f_act_q == '0) |-> !wrap_w);
  // R3
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(en_i) |-> $stable(phase_q));
endmodule

// File: rtl/nco_frac_div.sv
module nco_frac_div
  import nco_fd_pkg::*;
#(
  parameter int ACC_W  = 64,
  parameter int DIV_W  = 16,
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic [ACC_W-1:0]  rem_i,
  input  logic [ACC_W-1:0]  den_i,
  output logic [CODE_W-1:0] code_o,
  output logic              vld_o,
  output logic              busy_o
);
  localparam int CNT_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;

  function automatic int lead_one(input logic [ACC_W-1:0] x);
    int pos;
    pos = 0;
    for (int i = 0; i < ACC_W; i++) if (x[i]) pos = i;
    return pos;
  endfunction

  function automatic logic [DIV_W-1:0] top_bits(input logic [ACC_W-1:0] x, input int sh);
    logic [ACC_W-1:0] t;
    t = x << sh;
    return t[ACC_W-1 -: DIV_W];
  endfunction

  div_state_e        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DIV_W-1:0]  dd_q, part_q;
  logic [CODE_W-1:0] quo_q;
  logic              sat_q;
  logic [DIV_W:0]    trial_w;
  logic              bit_w;
  logic [DIV_W-1:0]  part_n_w;
  int                sh_w;
  logic [DIV_W-1:0]  nn_w, dn_w;

  assign sh_w     = ACC_W - 1 - lead_one(den_i);
  assign nn_w     = top_bits(den_i - rem_i, sh_w);
  assign dn_w     = top_bits(den_i, sh_w);
  assign trial_w  = {part_q, 1'b0};
  assign bit_w    = trial_w >= {1'b0, dd_q};
  assign part_n_w = bit_w ? DIV_W'(trial_w - {1'b0, dd_q}) : trial_w[DIV_W-1:0];
  assign busy_o   = (st_q == DV_RUN);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      st_q <= DV_IDLE; cnt_q <= '0; dd_q <= '0; part_q <= '0;
      quo_q <= '0; sat_q <= 1'b0; code_o <= '0; vld_o <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (start_i) begin
        st_q   <= DV_RUN;
        cnt_q  <= '0;
        dd_q   <= dn_w;
        sat_q  <= (nn_w >= dn_w);
        part_q <= (nn_w >= dn_w) ? '0 : nn_w;
        quo_q  <= '0;
      end else if (st_q == DV_RUN) begin
        part_q <= part_n_w;
        quo_q  <= {quo_q[CODE_W-2:0], bit_w};
        cnt_q  <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(CODE_W - 1)) begin
          st_q   <= DV_IDLE;
          vld_o  <= 1'b1;
          code_o <= sat_q ? '1 : {quo_q[CODE_W-2:0], bit_w};
        end
      end
    end
  end

  // R8
  no_restart_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    start_i |-> !busy_o);
  // R4
  part_below_den_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_o |-> (part_q < dd_q));
  // R5
  vld_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    vld_o |=> !vld_o);
endmodule

// File: rtl/nco_fine_edge.sv
module nco_fine_edge #(
  parameter int ACC_W   = 64,
  parameter int CODE_W  = 8,
  parameter int DIV_W   = 16,
  parameter int MIN_PER = 12
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              en_i,
  input  logic              freq_ld_i,
  input  logic [ACC_W-1:0]  freq_word_i,
  output logic              edge_o,
  output logic              clk_o,
  output logic [CODE_W-1:0] fine_code_o,
  output logic              fine_vld_o
);
  logic             wrap_w, div_busy_w;
  logic [ACC_W-1:0] rem_w, f_act_w;
  logic             edge_q, tog_q;

  nco_phase_acc #(.ACC_W(ACC_W), .MIN_PER(MIN_PER)) u_acc (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .ld_i(freq_ld_i),
    .word_i(freq_word_i), .wrap_o(wrap_w), .rem_o(rem_w), .f_act_o(f_act_w)
  );

  nco_frac_div #(.ACC_W(ACC_W), .DIV_W(DIV_W), .CODE_W(CODE_W)) u_div (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(wrap_w), .rem_i(rem_w),
    .den_i(f_act_w), .code_o(fine_code_o), .vld_o(fine_vld_o), .busy_o(div_busy_w)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      edge_q <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      edge_q <= wrap_w;
      if (wrap_w) tog_q <= ~tog_q;
    end
  end

  assign edge_o = edge_q;
  assign clk_o  = tog_q;

  // R7
  toggle_on_edge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    edge_o |-> (clk_o != $past(clk_o)));
  // R7
  steady_between_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !edge_o |-> $stable(clk_o));
  // R5
  busy_after_edge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    edge_o |-> div_busy_w);
endmodule

// File: tb/nco_fine_edge_bench.sv
module nco_fine_edge_bench;
  localparam longint unsigned F_CEIL_B = 64'hFFFF_FFFF_FFFF_FFFF / 12;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, ld = 1'b0;
  logic [63:0] word = '0;
  logic edge_s, clk_s, vld_s;
  logic [7:0] code_s;
  int total = 0, bad = 0;
  bit done = 0;

  always #2ns clk = ~clk;

  nco_fine_edge u_nco_fine_edge (
    .clk_i(clk), .rst_i(rst), .en_i(en), .freq_ld_i(ld), .freq_word_i(word),
    .edge_o(edge_s), .clk_o(clk_s), .fine_code_o(code_s), .fine_vld_o(vld_s)
  );

  // ideal model state
  logic [63:0] m_ph, m_f, m_hold;
  bit m_pend, m_edge, m_tog;
  longint k = 0, due = -1, last_edge = -1, min_gap = 1000000;
  int exp_code = 0, seg_edges = 0;

  function automatic int ideal_code(input logic [63:0] f, input logic [63:0] r);
    logic [127:0] num;
    logic [127:0] q;
    num = {64'b0, f - r} << 8;
    q = num / {64'b0, f};
    return (q > 255) ? 255 : int'(q);
  endfunction

  function automatic logic [63:0] ceil_word(input logic [63:0] w);
    return (w > F_CEIL_B) ? F_CEIL_B : w;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at step %0d: actual=%0d expected=%0d", req, k, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ph = '0; m_f = '0; m_hold = '0; m_pend = 0; m_edge = 0; m_tog = 0; due = -1;
  endtask

  // one reference cycle: check previous results, drive, predict
  task automatic tick(input bit e, input bit l, input logic [63:0] w);
    logic [64:0] s;
    bit wr;
    @(negedge clk);
    if (!rst) begin
      chk(edge_s == m_edge, "R2 edge", edge_s, m_edge);
      chk(clk_s == m_tog, "R7 clk", clk_s, m_tog);
      chk(vld_s == (due == k), "R5 vld", vld_s, due == k);
      if (vld_s && due == k) begin
        int d;
        d = int'(code_s) - exp_code;
        chk(d <= 1 && d >= -1, "R4 code", code_s, exp_code);
      end
    end
    en = e; ld = l; word = w;
    k++;
    s = {1'b0, m_ph} + {1'b0, m_f};
    wr = e && s[64];
    m_edge = wr;
    if (wr) begin
      m_tog = !m_tog;
      due = k + 8;
      exp_code = ideal_code(m_f, s[63:0]);
      seg_edges++;
      if (last_edge >= 0 && (k - last_edge) < min_gap) min_gap = k - last_edge;
      last_edge = k;
    end
    if (e) m_ph = s[63:0];
    if (m_pend && (wr || m_f == '0)) begin m_f = m_hold; m_pend = 0; end
    if (l) begin m_hold = ceil_word(w); m_pend = 1; end
  endtask

  task automatic run(input int n, input bit e);
    for (int i = 0; i < n; i++) tick(e, 1'b0, '0);
  endtask

  initial begin
    #(4ns * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd7);
    void'($urandom(32'd7));
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(edge_s == 0 && clk_s == 0 && vld_s == 0 && code_s == 0, "R1 reset", {edge_s, clk_s, vld_s}, 0);
    @(negedge clk); rst = 0;
    tick(1'b1, 1'b0, '0);
    chk(edge_s == 0 && clk_s == 0 && vld_s == 0, "R1 after reset", {edge_s, clk_s, vld_s}, 0);

    // R9 zero word: silence
    seg_edges = 0; run(60, 1'b1);
    chk(seg_edges == 0 && edge_s == 0, "R9 zero word", seg_edges, 0);

    // R4 exact boundaries: 2^60 gives remainder 0 every carry
    tick(1'b1, 1'b1, 64'h1000_0000_0000_0000);
    seg_edges = 0; run(170, 1'b1);
    chk(seg_edges == 10, "R2 period 16", seg_edges, 10);

    // R6 load mid-period waits for carry
    run(5, 1'b1);
    tick(1'b1, 1'b1, 64'h0C00_0000_0000_0000);
    run(120, 1'b1);

    // R8 oversize word clamps
    tick(1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    run(30, 1'b1);
    min_gap = 1000000; seg_edges = 0;
    run(200, 1'b1);
    chk(min_gap >= 12 && seg_edges > 0, "R8 min period", min_gap, 12);

    // R3 enable low: no edges, phase held
    seg_edges = 0; run(40, 1'b0);
    chk(seg_edges == 0 && edge_s == 0, "R3 disabled", seg_edges, 0);
    run(60, 1'b1);

    // R6 load at a carry edge: wait until the model predicts a carry next
    begin
      logic [64:0] s;
      for (int i = 0; i < 40; i++) begin
        s = {1'b0, m_ph} + {1'b0, m_f};
        if (s[64]) break;
        tick(1'b1, 1'b0, '0);
      end
      tick(1'b1, 1'b1, 64'h0400_0000_0000_0123);
      run(200, 1'b1);
    end

    // R2 R4 R6 random words, sometimes back-to-back loads
    for (int seg = 0; seg < 40; seg++) begin
      logic [63:0] w;
      int len;
      w = {$urandom, $urandom};
      w = 64'h0200_0000_0000_0000 + (w % (F_CEIL_B - 64'h0200_0000_0000_0000 + 64'd40));
      tick(1'b1, 1'b1, w);
      if ($urandom % 4 == 0) tick(1'b1, 1'b1, {$urandom, $urandom} >> 3);
      len = 100 + int'($urandom % 500);
      for (int i = 0; i < len; i++) tick(($urandom % 16) != 0, 1'b0, '0);
    end

    // R9 back to zero: edges stop after next carry
    tick(1'b1, 1'b1, '0);
    run(300, 1'b1);
    seg_edges = 0; run(100, 1'b1);
    chk(seg_edges == 0, "R9 stop on zero", seg_edges, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule